// File: doc/BRIEF.md
# Write-Through Cache Write-Miss Controller

This block is a direct-mapped cache controller whose main concern is what happens when a CPU store misses. It keeps a tag, a line-valid bit, a dirty bit and one valid bit per word for every line. A run-time input selects one of three write-miss policies. Fetch-allocate reads the whole block and then merges the store. Write-around sends the store to memory and leaves the cache alone. Write-validate claims the line without reading it and marks only the stored word valid. A second input selects whether store hits go to memory as well (write-through) or stay in the cache and set the dirty bit (write-back). A third input enables a write-before-hit timing mode. In that mode the data array is written in the same cycle as the tag compare, so a miss needs a corrective step afterwards.

The CPU side transfers one word per handshake. A request completes on the rising edge where `cpu_req` and `cpu_ready` are both high, and the request must be held until then. Read hits, and store hits in write-back mode, finish in the cycle of the request. Every other operation passes through the memory side, which moves one word per handshake: `mem_req` is held until a one-cycle `mem_ack`. Blocks move as consecutive word transfers in ascending offset order, starting at offset 0. The mode inputs are sampled when a request is accepted, and changes during an operation are ignored.

The controller is built around six states:
- `ST_IDLE` looks up the request and either completes it or leaves.
- `ST_EVICT` writes back the valid words of a dirty victim.
- `ST_FILL` fetches a block and fills only the words that are not valid.
- `ST_UPD` merges the stored word after a fill or an allocation.
- `ST_MEMWR` performs a single-word memory write.
- `ST_RESP` returns `cpu_ready` for one cycle.

The state transitions are:
- IDLE→IDLE on a fast hit.
- IDLE→FILL on a read miss or a fetch-allocate miss with a clean victim.
- IDLE→EVICT on an allocating miss with a dirty victim.
- IDLE→UPD on a write-validate miss with a clean victim.
- IDLE→MEMWR on a write-through hit or a write-around miss.
- EVICT→FILL or EVICT→UPD after the last victim word.
- FILL→UPD (store) or FILL→RESP (load) after the last word.
- UPD→MEMWR (write-through) or UPD→RESP (write-back).
- MEMWR→RESP on acknowledge.
- RESP→IDLE.

Top module: `wt_miss_ctrl`

## Requirements
- R1: After reset every line is invalid and nothing is dirty. `mem_req` is low, and `cpu_ready` is low while no request is present.
- R2: A store hit (tag equal and line valid) writes the cache word and sets its valid bit. With `cfg_wb`=0 the word is also written to memory with one memory write. With `cfg_wb`=1 no memory access occurs and the line becomes dirty.
- R3: A load whose tag matches on a valid line whose word-valid bit is set completes in the request cycle, with no memory access and `cpu_rdata` equal to the cached word.
- R4: A load miss reads all WORDS words of the block from memory, offsets 0 to WORDS-1 in ascending order, and then returns the requested word.
- R5: With `cfg_miss`=0 (or 3), a store miss allocates the line, fetches the whole block, then writes the word into the cache. In write-through mode it then writes the word to memory.
- R6: With `cfg_miss`=1, a store miss performs exactly one memory write and changes no tag, valid bit or dirty bit (except as stated in R9).
- R7: With `cfg_miss`=2, a store miss allocates the line with all word-valid bits clear except the stored word's. There is no memory read, and the word is written to memory only in write-through mode.
- R8: A load that matches the tag but finds its word invalid fetches the whole block. Words that are already valid keep their cached contents.
- R9: With `cfg_wbh`=1 and write-through, a write-around miss clears the valid bit of the word overwritten in the indexed line. A later load of the old tag therefore refetches it.
- R10: With `cfg_wbh`=1 and write-through, an allocating miss (`cfg_miss` 0 or 2) rewrites the stored word after the fetch or allocation, so a later load returns the stored value.
- R11: In write-back mode, an allocating miss whose victim is valid and dirty first writes every valid word of the victim to memory, then fetches or allocates.
- R12: `cpu_ready` is low whenever `mem_req` is high. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held stable until `mem_ack`.
- R13: `cfg_wb`, `cfg_miss` and `cfg_wbh` are sampled when a request is accepted. Changing them during the operation does not alter it.
- R14: `cfg_wbh` has no effect when `cfg_wb`=1: a write-around miss leaves the cached word and its valid bit intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wb | input | 1 | Store-hit policy: 0 write-through, 1 write-back |
| cfg_miss | input | 2 | Store-miss policy: 0/3 fetch-allocate, 1 write-around, 2 write-validate |
| cfg_wbh | input | 1 | Write-before-hit timing mode (write-through only) |
| cpu_req | input | 1 | CPU request, held until accepted |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Request completes on this edge |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 memory write, 0 memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |

## Verification
The hardest situation to reach is the write-before-hit corrective invalidate. It needs a line that already holds a different tag with the target word valid, and it needs that word's data to have been silently overwritten by a missing store. The stimulus first fills a line under one tag in write-through mode. It then issues a write-around store with write-before-hit enabled to the same index and offset under another tag. Finally it loads the original address: the load must miss on that word alone and return the memory value, not the stray store data. A dirty victim that holds only one valid word is reached in a similar way. A write-validate store in write-back mode is followed by a load that maps to the same index, and the bench counts exactly one write-back.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVICT = 3'd1,
        ST_FILL  = 3'd2,
        ST_UPD   = 3'd3,
        ST_MEMWR = 3'd4,
        ST_RESP  = 3'd5
    } wtm_state_e;

    typedef enum logic [1:0] {
        MISS_FETCH    = 2'd0,
        MISS_AROUND   = 2'd1,
        MISS_VALIDATE = 2'd2,
        MISS_ALT      = 2'd3
    } wtm_miss_e;

endpackage

// File: rtl/wtm_line_store.sv
module wtm_line_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_lv,
    output logic              rd_dirty,
    output logic [WORDS-1:0]  rd_wv,
    output logic [DATA_W-1:0] rd_data,
    input  logic              m_we,
    input  logic [TAG_W-1:0]  m_tag,
    input  logic              m_lv,
    input  logic              m_dirty,
    input  logic [WORDS-1:0]  m_wv,
    input  logic              d_we,
    input  logic [OFS_W-1:0]  d_ofs,
    input  logic [DATA_W-1:0] d_data
);

    logic [TAG_W-1:0]  tag_q   [LINES];
    logic              lv_q    [LINES];
    logic              dirty_q [LINES];
    logic [WORDS-1:0]  wv_q    [LINES];
    logic [DATA_W-1:0] data_q  [LINES][WORDS];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lv_q[l]    <= 1'b0;
                dirty_q[l] <= 1'b0;
                wv_q[l]    <= '0;
            end else if (m_we && rd_idx == IDX_W'(l)) begin
                tag_q[l]   <= m_tag;
                lv_q[l]    <= m_lv;
                dirty_q[l] <= m_dirty;
                wv_q[l]    <= m_wv;
            end
        end
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (d_we && rd_idx == IDX_W'(l) && d_ofs == OFS_W'(w))
                    data_q[l][w] <= d_data;
            end
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_lv    = lv_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_wv    = wv_q[rd_idx];
    assign rd_data  = data_q[rd_idx][rd_ofs];

endmodule

// File: rtl/wtm_lookup.sv
module wtm_lookup #(
    parameter int WORDS = 4,
    parameter int TAG_W = 5,
    localparam int OFS_W = $clog2(WORDS)
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_lv,
    input  logic [WORDS-1:0] line_wv,
    output logic             tag_hit,
    output logic             word_hit
);

    assign tag_hit  = line_lv && (line_tag == req_tag);
    assign word_hit = tag_hit && line_wv[req_ofs];

endmodule

// File: rtl/wt_miss_ctrl.sv
module wt_miss_ctrl
    import wtm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wb,
    input  logic [1:0]        cfg_miss,
    input  logic              cfg_wbh,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int OFS_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(WORDS - 1);

    wtm_state_e state, state_n;
    logic [OFS_W-1:0]  cnt, cnt_n;
    logic              op_we, op_wb;
    wtm_miss_e         op_miss;
    logic [TAG_W-1:0]  op_tag;
    logic [IDX_W-1:0]  op_idx;
    logic [OFS_W-1:0]  op_ofs;
    logic [DATA_W-1:0] op_wdata;

    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] cpu_idx;
    logic [OFS_W-1:0] cpu_ofs;
    assign {cpu_tag, cpu_idx, cpu_ofs} = cpu_addr;

    logic             idle;
    logic [TAG_W-1:0] cur_tag;
    logic [IDX_W-1:0] cur_idx;
    logic [OFS_W-1:0] cur_ofs, rd_ofs;
    assign idle    = (state == ST_IDLE);
    assign cur_tag = idle ? cpu_tag : op_tag;
    assign cur_idx = idle ? cpu_idx : op_idx;
    assign cur_ofs = idle ? cpu_ofs : op_ofs;
    assign rd_ofs  = (state == ST_EVICT) ? cnt : cur_ofs;

    logic [TAG_W-1:0]  s_tag;
    logic              s_lv, s_dirty;
    logic [WORDS-1:0]  s_wv;
    logic [DATA_W-1:0] s_data;
    logic              m_we, m_lv, m_dirty, d_we;
    logic [TAG_W-1:0]  m_tag;
    logic [WORDS-1:0]  m_wv;
    logic [OFS_W-1:0]  d_ofs;
    logic [DATA_W-1:0] d_data;
    logic              tag_hit, word_hit;

    wtm_line_store #(
        .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(cur_idx), .rd_ofs(rd_ofs),
        .rd_tag(s_tag), .rd_lv(s_lv), .rd_dirty(s_dirty), .rd_wv(s_wv), .rd_data(s_data),
        .m_we(m_we), .m_tag(m_tag), .m_lv(m_lv), .m_dirty(m_dirty), .m_wv(m_wv),
        .d_we(d_we), .d_ofs(d_ofs), .d_data(d_data)
    );

    wtm_lookup #(.WORDS(WORDS), .TAG_W(TAG_W)) u_lookup (
        .req_tag(cur_tag), .req_ofs(cur_ofs),
        .line_tag(s_tag), .line_lv(s_lv), .line_wv(s_wv),
        .tag_hit(tag_hit), .word_hit(word_hit)
    );

    // Live mode decode, used only in ST_IDLE
    wtm_miss_e live_miss;
    logic      wbh_live, victim_dirty, cnt_last, evict_step;
    logic [WORDS-1:0] cpu_bit, op_bit, cnt_bit;
    assign live_miss    = wtm_miss_e'(cfg_miss);
    assign wbh_live     = cfg_wbh && !cfg_wb;
    assign victim_dirty = s_lv && s_dirty;
    assign cnt_last     = (cnt == LAST_OFS);
    assign evict_step   = !s_wv[cnt] || mem_ack;
    assign cpu_bit      = WORDS'(1) << cpu_ofs;
    assign op_bit       = WORDS'(1) << op_ofs;
    assign cnt_bit      = WORDS'(1) << cnt;

    // State and operation registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
        if (idle && cpu_req) begin
            op_we    <= cpu_we;
            op_wb    <= cfg_wb;
            op_miss  <= live_miss;
            op_tag   <= cpu_tag;
            op_idx   <= cpu_idx;
            op_ofs   <= cpu_ofs;
            op_wdata <= cpu_wdata;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (cpu_req) begin
                    if (!cpu_we) begin
                        if (word_hit)          state_n = ST_IDLE;
                        else if (tag_hit)      state_n = ST_FILL;
                        else if (victim_dirty) state_n = ST_EVICT;
                        else                   state_n = ST_FILL;
                    end else if (tag_hit) begin
                        state_n = cfg_wb ? ST_IDLE : ST_MEMWR;
                    end else if (live_miss == MISS_AROUND) begin
                        state_n = ST_MEMWR;
                    end else if (victim_dirty) begin
                        state_n = ST_EVICT;
                    end else begin
                        state_n = (live_miss == MISS_VALIDATE) ? ST_UPD : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (evict_step) begin
                    if (cnt_last) begin
                        cnt_n   = '0;
                        state_n = (op_we && op_miss == MISS_VALIDATE) ? ST_UPD : ST_FILL;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    if (cnt_last) begin
                        cnt_n   = '0;
                        state_n = op_we ? ST_UPD : ST_RESP;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_UPD:   state_n = op_wb ? ST_RESP : ST_MEMWR;
            ST_MEMWR: if (mem_ack) state_n = ST_RESP;
            ST_RESP:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Outputs and storage commands
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = s_data;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        m_we      = 1'b0;
        m_tag     = s_tag;
        m_lv      = s_lv;
        m_dirty   = s_dirty;
        m_wv      = s_wv;
        d_we      = 1'b0;
        d_ofs     = cur_ofs;
        d_data    = op_wdata;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    d_data = cpu_wdata;
                    if (!cpu_we) begin
                        cpu_ready = word_hit;
                        if (!tag_hit && !victim_dirty) begin
                            m_we = 1'b1; m_tag = cpu_tag; m_lv = 1'b1;
                            m_dirty = 1'b0; m_wv = '0;
                        end
                    end else begin
                        d_we = wbh_live;
                        if (tag_hit) begin
                            cpu_ready = cfg_wb;
                            d_we      = 1'b1;
                            m_we      = 1'b1;
                            m_dirty   = s_dirty || cfg_wb;
                            m_wv      = s_wv | cpu_bit;
                        end else if (live_miss == MISS_AROUND) begin
                            if (wbh_live) begin
                                m_we = 1'b1;
                                m_wv = s_wv & ~cpu_bit;
                            end
                        end else if (!victim_dirty) begin
                            m_we = 1'b1; m_tag = cpu_tag; m_lv = 1'b1;
                            m_dirty = 1'b0; m_wv = '0;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = s_wv[cnt];
                mem_we    = 1'b1;
                mem_addr  = {s_tag, op_idx, cnt};
                mem_wdata = s_data;
                if (evict_step && cnt_last) begin
                    m_we = 1'b1; m_tag = op_tag; m_lv = 1'b1;
                    m_dirty = 1'b0; m_wv = '0;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {op_tag, op_idx, cnt};
                if (mem_ack && !s_wv[cnt]) begin
                    d_we   = 1'b1;
                    d_ofs  = cnt;
                    d_data = mem_rdata;
                    m_we   = 1'b1;
                    m_wv   = s_wv | cnt_bit;
                end
            end
            ST_UPD: begin
                d_we    = 1'b1;
                m_we    = 1'b1;
                m_dirty = s_dirty || op_wb;
                m_wv    = s_wv | op_bit;
            end
            ST_MEMWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {op_tag, op_idx, op_ofs};
                mem_wdata = op_wdata;
            end
            ST_RESP:  cpu_ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wtm_ctrl_chk.sv
module wtm_ctrl_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R12: the CPU never completes while memory is busy
    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    // R12: a memory request is held unchanged until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R4: block reads step through consecutive word addresses
    a_r4_fill_order: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we && (mem_addr[OFS_W-1:0] != {OFS_W{1'b1}}))
        |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + 1'b1));

    // R3: completion is only signalled to a waiting request
    a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req);

    // R12: an acknowledge is only accepted for a pending request
    a_r12_ack_with_req: assert property (@(posedge clk) disable iff (rst)
        mem_ack |-> mem_req);

endmodule

bind wt_miss_ctrl wtm_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/test_wt_miss_ctrl.sv
`timescale 1ns/1ps
module test_wt_miss_ctrl;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LAT = 2;
    localparam int NVEC = 37;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wb = 1'b0, cfg_wbh = 1'b0;
    logic [1:0]    cfg_miss = 2'd0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #4 clk = ~clk;

    wt_miss_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .WORDS(4)) i_wt_miss_ctrl (
        .clk(clk), .rst(rst), .cfg_wb(cfg_wb), .cfg_miss(cfg_miss), .cfg_wbh(cfg_wbh),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    logic [DW-1:0] mem [1<<AW];
    logic [DW-1:0] cv  [1<<AW];
    int nrd = 0, nwr = 0, lat = 0;
    int checks = 0, fails = 0;
    logic [DW-1:0] got;
    int d_rd, d_wr;
    bit overlap_seen;

    function automatic logic [AW-1:0] adr(int t, int i, int w);
        return AW'(t * 32 + i * 4 + w);
    endfunction

    // we, addr, wb, miss, wbh, expected reads, expected writes, requirement
    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic          wb;
        logic [1:0]    mm;
        logic          wbh;
        logic [2:0]    erd;
        logic [2:0]    ewr;
        logic [3:0]    rq;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, adr(1,0,0),  1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 4'd4},  // R4 cold load
        '{1'b0, adr(1,0,2),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd3},  // R3 hit
        '{1'b1, adr(1,0,1),  1'b0, 2'd0, 1'b0, 3'd0, 3'd1, 4'd2},  // R2 WT hit
        '{1'b0, adr(1,0,1),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd2},
        '{1'b1, adr(2,1,0),  1'b0, 2'd1, 1'b0, 3'd0, 3'd1, 4'd6},  // R6 around
        '{1'b0, adr(2,1,0),  1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 4'd6},
        '{1'b1, adr(3,1,3),  1'b0, 2'd1, 1'b0, 3'd0, 3'd1, 4'd6},
        '{1'b0, adr(2,1,3),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd6},
        '{1'b1, adr(4,2,1),  1'b0, 2'd0, 1'b0, 3'd4, 3'd1, 4'd5},  // R5 fetch-allocate
        '{1'b0, adr(4,2,3),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd5},
        '{1'b0, adr(4,2,1),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd5},
        '{1'b1, adr(5,3,2),  1'b0, 2'd2, 1'b0, 3'd0, 3'd1, 4'd7},  // R7 validate
        '{1'b0, adr(5,3,2),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd7},
        '{1'b0, adr(5,3,0),  1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 4'd8},  // R8 partial
        '{1'b0, adr(5,3,2),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd8},
        '{1'b1, adr(6,0,1),  1'b0, 2'd1, 1'b1, 3'd0, 3'd1, 4'd9},  // R9 invalidate
        '{1'b0, adr(1,0,1),  1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 4'd9},
        '{1'b0, adr(1,0,0),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd9},
        '{1'b1, adr(7,2,0),  1'b0, 2'd0, 1'b1, 3'd4, 3'd1, 4'd10}, // R10 rewrite
        '{1'b0, adr(7,2,0),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd10},
        '{1'b1, adr(8,3,1),  1'b0, 2'd2, 1'b1, 3'd0, 3'd1, 4'd10},
        '{1'b0, adr(8,3,1),  1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd10},
        '{1'b0, adr(8,3,0),  1'b0, 2'd0, 1'b0, 3'd4, 3'd0, 4'd10},
        '{1'b1, adr(1,0,2),  1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 4'd2},  // R2 WB hit
        '{1'b0, adr(1,0,2),  1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 4'd2},
        '{1'b0, adr(9,0,0),  1'b1, 2'd0, 1'b0, 3'd4, 3'd4, 4'd11}, // R11 full evict
        '{1'b0, adr(1,0,2),  1'b1, 2'd0, 1'b0, 3'd4, 3'd0, 4'd11},
        '{1'b1, adr(10,4,3), 1'b1, 2'd2, 1'b0, 3'd0, 3'd0, 4'd7},
        '{1'b0, adr(11,4,0), 1'b1, 2'd0, 1'b0, 3'd4, 3'd1, 4'd11}, // R11 one valid word
        '{1'b0, adr(10,4,3), 1'b1, 2'd0, 1'b0, 3'd4, 3'd0, 4'd11},
        '{1'b1, adr(12,5,0), 1'b1, 2'd0, 1'b0, 3'd4, 3'd0, 4'd5},
        '{1'b0, adr(12,5,0), 1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 4'd5},
        '{1'b1, adr(13,5,0), 1'b1, 2'd1, 1'b0, 3'd0, 3'd1, 4'd6},
        '{1'b0, adr(12,5,0), 1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 4'd6},
        '{1'b0, adr(14,6,0), 1'b1, 2'd0, 1'b0, 3'd4, 3'd0, 4'd4},
        '{1'b1, adr(15,6,1), 1'b1, 2'd1, 1'b1, 3'd0, 3'd1, 4'd14}, // R14 wbh ignored
        '{1'b0, adr(14,6,1), 1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 4'd14}
    };

    // Memory model: fixed latency, one-cycle acknowledge
    initial begin
        for (int a = 0; a < (1 << AW); a++) begin
            mem[a] = 32'hC0DE0000 | a;
            cv[a]  = 32'hC0DE0000 | a;
        end
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat = 0;
            end else if (mem_req && !rst) begin
                lat++;
                if (lat >= LAT) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        nwr++;
                    end else begin
                        mem_rdata = mem[mem_addr];
                        nrd++;
                    end
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One CPU operation; flip changes the mode inputs while it is in flight
    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic wb, input logic [1:0] mm, input logic wbh, input bit flip);
        int rd0, wr0, t;
        @(negedge clk);
        cfg_wb = wb; cfg_miss = mm; cfg_wbh = wbh;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        rd0 = nrd; wr0 = nwr; t = 0;
        #1;
        while (!cpu_ready && t < 400) begin
            @(negedge clk);
            #1;
            t++;
            if (mem_req && cpu_ready) overlap_seen = 1'b1;
            if (flip && t == 2) begin
                cfg_wb = ~wb; cfg_miss = 2'd1; cfg_wbh = 1'b1;
            end
        end
        check(t < 400, 12, "operation timed out", DW'(t), 32'd400);
        got = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        d_rd = nrd - rd0;
        d_wr = nwr - wr0;
        if (we) cv[a] = wd;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        overlap_seen = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check(mem_req == 1'b0, 1, "mem_req after reset", DW'(mem_req), 32'd0);
        check(cpu_ready == 1'b0, 1, "cpu_ready after reset", DW'(cpu_ready), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [DW-1:0] wd;
            wd = 32'hDA7A0000 + i;
            cpu_op(VEC[i].we, VEC[i].a, wd, VEC[i].wb, VEC[i].mm, VEC[i].wbh, 1'b0);
            check(d_rd == int'(VEC[i].erd), int'(VEC[i].rq), $sformatf("vec %0d memory reads", i),
                  DW'(d_rd), DW'(VEC[i].erd));
            check(d_wr == int'(VEC[i].ewr), int'(VEC[i].rq), $sformatf("vec %0d memory writes", i),
                  DW'(d_wr), DW'(VEC[i].ewr));
            if (!VEC[i].we)
                check(got == cv[VEC[i].a], int'(VEC[i].rq), $sformatf("vec %0d load data", i),
                      got, cv[VEC[i].a]);
        end

        // R13: modes changed mid-operation are ignored (fetch-allocate, write-through)
        cpu_op(1'b1, adr(16,7,0), 32'hFEED0013, 1'b0, 2'd0, 1'b0, 1'b1);
        check(d_rd == 4, 13, "mode flip memory reads", DW'(d_rd), 32'd4);
        check(d_wr == 1, 13, "mode flip memory writes", DW'(d_wr), 32'd1);
        check(mem[adr(16,7,0)] == 32'hFEED0013, 13, "mode flip memory word",
              mem[adr(16,7,0)], 32'hFEED0013);
        cpu_op(1'b0, adr(16,7,0), '0, 1'b0, 2'd0, 1'b0, 1'b0);
        check(d_rd == 0 && got == 32'hFEED0013, 13, "mode flip line allocated", got, 32'hFEED0013);

        // R12: ready never overlapped a memory request
        check(!overlap_seen, 12, "ready during memory request", DW'(overlap_seen), 32'd0);

        // R1: reset empties the cache and clears dirty state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_req == 1'b0 && cpu_ready == 1'b0, 1, "outputs in reset",
              DW'({mem_req, cpu_ready}), 32'd0);
        rst = 1'b0;
        cpu_op(1'b0, adr(16,7,0), '0, 1'b1, 2'd0, 1'b0, 1'b0);
        check(d_rd == 4 && d_wr == 0, 1, "load after reset misses",
              DW'(d_rd * 16 + d_wr), 32'd64);
        check(got == cv[adr(16,7,0)], 1, "load after reset data", got, cv[adr(16,7,0)]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule